// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a processor core and the interrupt flags of its peripherals. It collects requests on sixteen priority levels, picks the most urgent one that may run, and presents the word address of that level's entry in the vector table at the top of memory. The table starts at 0xFFE0 and holds one two-byte entry per level. The core takes the request with a single-cycle acknowledge. The controller then tells the core to drop its global interrupt enable, and for levels served by a single flag it sends an auto-clear pulse back to that flag.

There are three classes of request. The top level gathers every reset cause, and it always wins. The level below it gathers the critical events, which a per-source enable can block but the global enable cannot. All lower levels need both their own enable and the global enable. The block also watches instruction fetches. A fetch from the low register window 0x0000 to 0x01FF raises a reset request and is recorded as a reset cause. After reset the block inspects the first word read from the reset vector. If that word is the erased pattern 0xFFFF, the block asks for the deepest sleep mode and keeps the core from running.

Top module: `int_vec_ctrl`

## Requirements
- R1: After reset, irq_valid_o, gie_clr_o, flag_clr_o, rst_req_o, cause_o, sleep_o and run_o are all 0.
- R2: When several levels are pending, the highest-numbered one is presented. vec_addr_o equals 0xFFE0 + 2*irq_level_o.
- R3: A pending reset request (level 15, vector 0xFFFE) wins over every other level, whatever the enables are.
- R4: Level 14 is pending when any nmi_flag_i bit is set together with its nmi_en_i bit, whatever gie_i is. A flag whose enable bit is clear has no effect.
- R5: A level p in 0..13 is pending only when irq_req_i[p], irq_en_i[p] and gie_i are all 1.
- R6: Once irq_valid_o is 1, it stays 1 with an unchanged level and vector until a cycle with ack_i high, even if a higher level becomes pending meanwhile.
- R7: An acknowledge clears irq_valid_o at the next edge and blocks capture for one cycle. For levels 0..13 it also gives a one-cycle gie_clr_o pulse, plus a flag_clr_o[p] pulse when level p is single-source. By default levels 0, 6, 10, 11 and 13 are single-source. Levels 14 and 15 give no pulse.
- R8: A fetch (fetch_valid_i) from an address at or below 0x01FF gives a one-cycle rst_req_o pulse at the next edge, sets cause bit 4 and raises level 15. A fetch from 0x0200 or above does none of this.
- R9: cause_o bits 0..3 record the reset sources rst_src_i[0..3] (power-up, external pin, watchdog, flash key) and bit 4 records a protected-window fetch. The bits stay set until cause_clr_i clears them. A new event in the same cycle as cause_clr_i is kept.
- R10: The first rv_valid_i after reset decides the boot outcome. If rv_data_i is 0xFFFF, then sleep_o=1 and run_o=0. Otherwise sleep_o=0 and run_o=1. Later reads change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_src_i | input | 4 | Reset cause events: power-up, pin, watchdog, flash key |
| fetch_valid_i | input | 1 | Instruction fetch in progress |
| fetch_addr_i | input | 16 | Fetch address |
| nmi_flag_i | input | 3 | Critical-event flags for level 14 |
| nmi_en_i | input | 3 | Per-source enables for level 14 |
| irq_req_i | input | 14 | Per-level requests for levels 0..13 (OR of module flags) |
| irq_en_i | input | 14 | Per-level enables for levels 0..13 |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 1 | Core acknowledges the presented request |
| rv_valid_i | input | 1 | Reset-vector word is on rv_data_i |
| rv_data_i | input | 16 | Reset-vector word |
| cause_clr_i | input | 1 | Clear the reset cause record |
| irq_valid_o | output | 1 | A request is presented |
| irq_level_o | output | 4 | Presented level |
| vec_addr_o | output | 16 | Vector-table address of the presented level |
| gie_clr_o | output | 1 | Pulse: core must drop its global enable |
| flag_clr_o | output | 14 | Pulse: auto-clear the flag of a single-source level |
| rst_req_o | output | 1 | Pulse: fetch from the protected window |
| cause_o | output | 5 | Recorded reset causes |
| sleep_o | output | 1 | Deepest sleep requested (erased reset vector) |
| run_o | output | 1 | Core may start execution |

## Verification
The assertions assume that ack_i is a single-cycle pulse that comes only while irq_valid_o is high. They also assume that every input is synchronous to clk_i and that the core drops gie_i and the flag owners drop auto-cleared requests once the matching pulse appears. The bench drives every input on the falling edge. It raises ack_i for exactly one cycle and only after it has seen a presented request. It models the core and the flag owners by lowering gie_i and the served request on the cycle in which gie_clr_o or flag_clr_o is seen. Reset-cause events and protected fetches are held for one cycle only, so each is counted as a single event.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef logic [15:0] addr_t;

  localparam int CAUSE_POR   = 0;
  localparam int CAUSE_PIN   = 1;
  localparam int CAUSE_WDT   = 2;
  localparam int CAUSE_KEY   = 3;
  localparam int CAUSE_FETCH = 4;

  function automatic addr_t lvl_vec(addr_t base, int unsigned lvl);
    return base + addr_t'(lvl * 2);
  endfunction
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int N_LVL = 16,
  parameter int N_NMI = 3,
  localparam int N_MASK = N_LVL - 2
) (
  input  logic [N_MASK-1:0] irq_req_i,
  input  logic [N_MASK-1:0] irq_en_i,
  input  logic              gie_i,
  input  logic [N_NMI-1:0]  nmi_flag_i,
  input  logic [N_NMI-1:0]  nmi_en_i,
  input  logic              rst_pend_i,
  output logic [N_LVL-1:0]  pend_o
);
  // fully maskable levels
  for (genvar i = 0; i < N_MASK; i++) begin : g_mask
    assign pend_o[i] = irq_req_i[i] & irq_en_i[i] & gie_i;
  end
  // global enable does not gate level N_LVL-2
  assign pend_o[N_LVL-2] = |(nmi_flag_i & nmi_en_i);
  assign pend_o[N_LVL-1] = rst_pend_i;
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter import ivc_pkg::*; #(
  parameter int    N_LVL    = 16,
  parameter addr_t VEC_BASE = 16'hFFE0,
  localparam int   N_MASK   = N_LVL - 2,
  localparam int   LW       = $clog2(N_LVL),
  parameter logic [N_MASK-1:0] MULTI_SRC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LVL-1:0]  pend_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [LW-1:0]     level_o,
  output addr_t             vec_o,
  output logic              gie_clr_o,
  output logic [N_MASK-1:0] flag_clr_o,
  output logic              rst_ack_o
);
  logic              valid_q, dead_q, gie_clr_q;
  logic [LW-1:0]     level_q, win;
  logic [N_MASK-1:0] flag_clr_q;
  logic              any_pend;

  assign any_pend = |pend_i;

  // last match wins, so the highest index takes priority
  always_comb begin
    win = '0;
    for (int i = 0; i < N_LVL; i++)
      if (pend_i[i]) win = LW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      level_q    <= '0;
      dead_q     <= 1'b0;
      gie_clr_q  <= 1'b0;
      flag_clr_q <= '0;
    end else begin
      dead_q     <= 1'b0;
      gie_clr_q  <= 1'b0;
      flag_clr_q <= '0;
      if (valid_q) begin
        if (ack_i) begin
          valid_q <= 1'b0;
          dead_q  <= 1'b1;
          for (int i = 0; i < N_MASK; i++)
            if (level_q == LW'(i)) begin
              gie_clr_q     <= 1'b1;
              flag_clr_q[i] <= ~MULTI_SRC[i];
            end
        end
      end else if (any_pend && !dead_q) begin
        valid_q <= 1'b1;
        level_q <= win;
      end
    end
  end

  assign valid_o    = valid_q;
  assign level_o    = level_q;
  assign vec_o      = lvl_vec(VEC_BASE, 32'(level_q));
  assign gie_clr_o  = gie_clr_q;
  assign flag_clr_o = flag_clr_q;
  assign rst_ack_o  = valid_q && ack_i && (level_q == LW'(N_LVL - 1));

  // R6
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ack_i |=> valid_q && $stable(level_q));
  // R7
  gie_clr_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_q |-> $past(ack_i) && !valid_q);
  // R7
  flag_clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_q) && (!(|flag_clr_q) || gie_clr_q));
  // R3
  reset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) && $past(pend_i[N_LVL-1]) |-> level_q == LW'(N_LVL - 1));
endmodule

// File: rtl/ivc_rst_ctl.sv
module ivc_rst_ctl import ivc_pkg::*; #(
  parameter int    N_SRC   = 4,
  parameter addr_t PROT_HI = 16'h01FF,
  parameter addr_t ERASED  = 16'hFFFF,
  localparam int   CW      = N_SRC + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N_SRC-1:0] rst_src_i,
  input  logic          fetch_valid_i,
  input  addr_t         fetch_addr_i,
  input  logic          cause_clr_i,
  input  logic          rst_ack_i,
  input  logic          rv_valid_i,
  input  addr_t         rv_data_i,
  output logic          rst_pend_o,
  output logic          rst_req_o,
  output logic [CW-1:0] cause_o,
  output logic          sleep_o,
  output logic          run_o
);
  logic          fetch_hit, pend_q, req_q, boot_q, sleep_q;
  logic [CW-1:0] ev, cause_q;

  assign fetch_hit = fetch_valid_i && (fetch_addr_i <= PROT_HI);
  assign ev        = {fetch_hit, rst_src_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      boot_q  <= 1'b1;
      sleep_q <= 1'b0;
    end else begin
      // a new event beats a clear in the same cycle
      cause_q <= (cause_clr_i ? '0 : cause_q) | ev;
      pend_q  <= (|ev) | (pend_q & ~rst_ack_i);
      req_q   <= fetch_hit;
      if (boot_q && rv_valid_i) begin
        boot_q  <= 1'b0;
        sleep_q <= (rv_data_i == ERASED);
      end
    end
  end

  assign rst_pend_o = pend_q;
  assign rst_req_o  = req_q;
  assign cause_o    = cause_q;
  assign sleep_o    = sleep_q;
  assign run_o      = !boot_q && !sleep_q;

  // R8
  fetch_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hit |=> rst_req_o && cause_q[CAUSE_FETCH] && pend_q);
  // R9
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_clr_i |=> (cause_q & $past(cause_q)) == $past(cause_q));
  // R10
  boot_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_q |=> !boot_q && $stable(sleep_q));
endmodule

// File: rtl/int_vec_ctrl.sv
module int_vec_ctrl import ivc_pkg::*; #(
  parameter int    N_LVL    = 16,
  parameter int    N_NMI    = 3,
  parameter int    N_SRC    = 4,
  parameter addr_t VEC_BASE = 16'hFFE0,
  parameter addr_t PROT_HI  = 16'h01FF,
  parameter addr_t ERASED   = 16'hFFFF,
  localparam int   N_MASK   = N_LVL - 2,
  localparam int   LW       = $clog2(N_LVL),
  parameter logic [N_MASK-1:0] MULTI_SRC = 14'h13BE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  rst_src_i,
  input  logic              fetch_valid_i,
  input  logic [15:0]       fetch_addr_i,
  input  logic [N_NMI-1:0]  nmi_flag_i,
  input  logic [N_NMI-1:0]  nmi_en_i,
  input  logic [N_MASK-1:0] irq_req_i,
  input  logic [N_MASK-1:0] irq_en_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic              rv_valid_i,
  input  logic [15:0]       rv_data_i,
  input  logic              cause_clr_i,
  output logic              irq_valid_o,
  output logic [LW-1:0]     irq_level_o,
  output logic [15:0]       vec_addr_o,
  output logic              gie_clr_o,
  output logic [N_MASK-1:0] flag_clr_o,
  output logic              rst_req_o,
  output logic [N_SRC:0]    cause_o,
  output logic              sleep_o,
  output logic              run_o
);
  logic [N_LVL-1:0] pend;
  logic             rst_pend, rst_ack;

  ivc_rst_ctl #(.N_SRC(N_SRC), .PROT_HI(PROT_HI), .ERASED(ERASED)) u_rst (
    .clk_i, .rst_ni, .rst_src_i, .fetch_valid_i, .fetch_addr_i, .cause_clr_i,
    .rst_ack_i(rst_ack), .rv_valid_i, .rv_data_i,
    .rst_pend_o(rst_pend), .rst_req_o, .cause_o, .sleep_o, .run_o);

  ivc_pending #(.N_LVL(N_LVL), .N_NMI(N_NMI)) u_pend (
    .irq_req_i, .irq_en_i, .gie_i, .nmi_flag_i, .nmi_en_i,
    .rst_pend_i(rst_pend), .pend_o(pend));

  ivc_arbiter #(.N_LVL(N_LVL), .VEC_BASE(VEC_BASE), .MULTI_SRC(MULTI_SRC)) u_arb (
    .clk_i, .rst_ni, .pend_i(pend), .ack_i,
    .valid_o(irq_valid_o), .level_o(irq_level_o), .vec_o(vec_addr_o),
    .gie_clr_o, .flag_clr_o, .rst_ack_o(rst_ack));

  // R5
  maskable_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_o) && (32'(irq_level_o) < N_MASK) |-> $past(gie_i));
  // R4
  nmi_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_o) && irq_level_o == LW'(N_LVL - 2) |-> $past(|(nmi_flag_i & nmi_en_i)));
endmodule

// File: tb/sim_int_vec_ctrl.sv
module sim_int_vec_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [3:0]  rst_src_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic [2:0]  nmi_flag_i = '0, nmi_en_i = '0;
  logic [13:0] irq_req_i = '0, irq_en_i = '0;
  logic        gie_i = 1'b0, ack_i = 1'b0, rv_valid_i = 1'b0, cause_clr_i = 1'b0;
  logic [15:0] rv_data_i = '0;
  logic        irq_valid_o, gie_clr_o, rst_req_o, sleep_o, run_o;
  logic [3:0]  irq_level_o;
  logic [15:0] vec_addr_o;
  logic [13:0] flag_clr_o;
  logic [4:0]  cause_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  int_vec_ctrl u0 (
    .clk_i(clk), .rst_ni, .rst_src_i, .fetch_valid_i, .fetch_addr_i, .nmi_flag_i,
    .nmi_en_i, .irq_req_i, .irq_en_i, .gie_i, .ack_i, .rv_valid_i, .rv_data_i,
    .cause_clr_i, .irq_valid_o, .irq_level_o, .vec_addr_o, .gie_clr_o, .flag_clr_o,
    .rst_req_o, .cause_o, .sleep_o, .run_o);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack;
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc();
  endtask

  task automatic t_reset;
    chk("R1 valid", irq_valid_o, 0);
    chk("R1 pulses", {gie_clr_o, flag_clr_o, rst_req_o}, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 sleep/run", {sleep_o, run_o}, 0);
  endtask

  task automatic t_boot_normal;
    rv_valid_i = 1'b1; rv_data_i = 16'h1234;
    cyc();
    rv_valid_i = 1'b0;
    chk("R10 run after good vector", {sleep_o, run_o}, 2'b01);
    rv_valid_i = 1'b1; rv_data_i = 16'hFFFF;
    cyc();
    rv_valid_i = 1'b0;
    chk("R10 later read ignored", {sleep_o, run_o}, 2'b01);
  endtask

  task automatic t_priority;
    gie_i = 1'b1; irq_en_i = 14'h3FFF;
    irq_req_i = (14'd1 << 3) | (14'd1 << 11);
    cyc();
    chk("R2 winner level", {irq_valid_o, irq_level_o}, {1'b1, 4'd11});
    chk("R2 vector 11", vec_addr_o, 16'hFFF6);
    do_ack();
    chk("R7 gie_clr single", gie_clr_o, 1);
    chk("R7 flag_clr single-source", flag_clr_o, 14'd1 << 11);
    chk("R7 valid dropped", irq_valid_o, 0);
    irq_req_i[11] = 1'b0; gie_i = 1'b0;
    cyc(3);
    chk("R5 gie off blocks level 3", irq_valid_o, 0);
    gie_i = 1'b1;
    cyc();
    chk("R2 vector 3", {irq_valid_o, irq_level_o, vec_addr_o}, {1'b1, 4'd3, 16'hFFE6});
    do_ack();
    chk("R7 multi-source no flag clr", {gie_clr_o, flag_clr_o}, {1'b1, 14'd0});
    irq_req_i = '0; gie_i = 1'b0;
    cyc(2);
  endtask

  task automatic t_mask;
    gie_i = 1'b1; irq_en_i = ~(14'd1 << 5); irq_req_i = 14'd1 << 5;
    cyc(3);
    chk("R5 enable off blocks level 5", irq_valid_o, 0);
    irq_en_i = 14'h3FFF; irq_req_i[0] = 1'b1;
    cyc();
    chk("R5 both enables", {irq_valid_o, irq_level_o}, {1'b1, 4'd5});
    do_ack();
    chk("R7 level 5 multi", {gie_clr_o, flag_clr_o}, {1'b1, 14'd0});
    irq_req_i[5] = 1'b0; gie_i = 1'b0;
    cyc(3);
    chk("R5 level 0 held back by gie", irq_valid_o, 0);
    gie_i = 1'b1;
    cyc();
    chk("R2 lowest vector", {irq_level_o, vec_addr_o}, {4'd0, 16'hFFE0});
    do_ack();
    chk("R7 level 0 auto clear", flag_clr_o, 14'd1);
    irq_req_i = '0; gie_i = 1'b0;
    cyc(2);
  endtask

  task automatic t_nmi;
    gie_i = 1'b0; nmi_flag_i = 3'b001; nmi_en_i = 3'b110;
    cyc(3);
    chk("R4 disabled source ignored", irq_valid_o, 0);
    nmi_en_i = 3'b111;
    cyc();
    chk("R4 level 14 with gie off", {irq_valid_o, irq_level_o, vec_addr_o}, {1'b1, 4'd14, 16'hFFFC});
    do_ack();
    chk("R7 no pulse for level 14", {gie_clr_o, flag_clr_o}, 0);
    nmi_flag_i = '0;
    cyc(2);
  endtask

  task automatic t_hold;
    gie_i = 1'b1; irq_en_i = 14'h3FFF; irq_req_i = 14'd1 << 2;
    cyc();
    chk("R2 level 2", irq_level_o, 2);
    nmi_flag_i = 3'b100;
    cyc(3);
    chk("R6 held despite higher", {irq_valid_o, irq_level_o, vec_addr_o}, {1'b1, 4'd2, 16'hFFE4});
    do_ack();
    irq_req_i = '0; gie_i = 1'b0;
    cyc();
    chk("R7 dead cycle after ack", irq_valid_o, 0);
    cyc();
    chk("R4 level 14 after hold", {irq_valid_o, irq_level_o}, {1'b1, 4'd14});
    do_ack();
    nmi_flag_i = '0;
    cyc(2);
  endtask

  task automatic t_reset_level;
    rst_src_i = 4'b0010;
    cyc();
    rst_src_i = '0; gie_i = 1'b1; nmi_flag_i = 3'b010; irq_req_i = 14'd1 << 13;
    cyc();
    chk("R3 reset wins", {irq_valid_o, irq_level_o, vec_addr_o}, {1'b1, 4'd15, 16'hFFFE});
    chk("R9 pin cause", cause_o, 5'b00010);
    do_ack();
    chk("R7 no pulse for reset", {gie_clr_o, flag_clr_o}, 0);
    cyc(2);
    chk("R2 level 14 next", irq_level_o, 14);
    do_ack();
    nmi_flag_i = '0;
    cyc(2);
    chk("R2 level 13 next", {irq_valid_o, irq_level_o, vec_addr_o}, {1'b1, 4'd13, 16'hFFFA});
    do_ack();
    chk("R7 level 13 auto clear", flag_clr_o, 14'd1 << 13);
    irq_req_i = '0; gie_i = 1'b0;
    cyc(2);
  endtask

  task automatic t_cause;
    rst_src_i = 4'b0100;
    cyc();
    rst_src_i = '0;
    chk("R9 sticky plus watchdog", cause_o, 5'b00110);
    cause_clr_i = 1'b1; rst_src_i = 4'b1000;
    cyc();
    cause_clr_i = 1'b0; rst_src_i = '0;
    chk("R9 set wins over clear", cause_o, 5'b01000);
    cause_clr_i = 1'b1;
    cyc();
    cause_clr_i = 1'b0;
    chk("R9 cleared", cause_o, 0);
    if (irq_valid_o) do_ack();
    cyc(2);
    if (irq_valid_o) do_ack();
    cyc(2);
  endtask

  task automatic t_fetch;
    fetch_valid_i = 1'b1; fetch_addr_i = 16'h0200;
    cyc();
    chk("R8 0x0200 no reset", {rst_req_o, cause_o}, 0);
    fetch_addr_i = 16'h01FF;
    cyc();
    fetch_valid_i = 1'b0;
    chk("R8 window fetch", {rst_req_o, cause_o}, {1'b1, 5'b10000});
    cyc();
    chk("R8 pulse ends, level 15", {rst_req_o, irq_valid_o, irq_level_o}, {2'b01, 4'd15});
    do_ack();
    cyc(2);
    chk("R8 reset level served once", irq_valid_o, 0);
  endtask

  task automatic t_boot_erased;
    do_reset();
    t_reset();
    rv_valid_i = 1'b1; rv_data_i = 16'hFFFF;
    cyc();
    rv_valid_i = 1'b0; rv_data_i = 16'h0000;
    chk("R10 erased vector sleeps", {sleep_o, run_o}, 2'b10);
    rv_valid_i = 1'b1;
    cyc();
    rv_valid_i = 1'b0;
    chk("R10 stays asleep", {sleep_o, run_o}, 2'b10);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_boot_normal();
    t_priority();
    t_mask();
    t_nmi();
    t_hold();
    t_reset_level();
    t_cause();
    t_fetch();
    t_boot_erased();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule